// File: doc/BRIEF.md
# Dual-Lane Packed Complex Multiplier

This block multiplies two pairs of complex numbers per clock. Each 64-bit operand word carries two complex elements. Each element has a signed 16-bit real part and a signed 16-bit imaginary part. The block forms the product of matching elements in both lanes at once.

A per-issue flag replaces the second operand by its complex conjugate before the multiply. A second per-issue flag picks the output format:
- a widened result, where every part is 32 bits and the whole result is 128 bits;
- a Q15 result, where every part is rounded and saturated back to 16 bits and the whole result packs into 64 bits.

A new operation may be issued on every cycle, with no handshake. Each issue carries a valid bit. That bit leaves the block together with the result of that issue after a fixed three-register pipeline. The datapath has no control states. The only sequencing is the valid and format tag, which walks through the three stages beside the data.

Top module: `cmul_dual`

## Requirements
- R1: Operands are two's complement. Lane 0 occupies bits [31:0] of each operand word and lane 1 occupies bits [63:32]. Inside each 32-bit element, the real part sits in the upper 16 bits and the imaginary part in the lower 16 bits.
- R2: With conjugation off, each lane yields real = a.re*b.re - a.im*b.im and imag = a.re*b.im + a.im*b.re, computed exactly. A zero second operand gives an all-zero result.
- R3: With `conj_i` high, the imaginary part of the second operand is negated at full precision before the multiply. This includes -32768, which becomes +32768.
- R4: With `rnd_i` low, lane k's result occupies `res_o[64k+63:64k]`, with the 32-bit real part in the upper half. A part equal to +2^31 is clipped to 0x7FFFFFFF.
- R5: With `rnd_i` high, each exact part has 2^14 added and is shifted arithmetically right by 15. A value above 32767 becomes 0x7FFF and a value below -32768 becomes 0x8000. Lane k's 32-bit result {real, imag} occupies `res_o[32k+31:32k]`, and `res_o[127:64]` is zero.
- R6: Inputs sampled at a rising edge appear on `vld_o`/`res_o` after the third rising edge. Issues may come on back-to-back cycles, and each keeps its own `conj_i`/`rnd_i` setting.
- R7: Whenever `vld_o` is low, `res_o` is all zeros.
- R8: An active-low asynchronous reset empties the pipeline: `vld_o` and `res_o` read zero during reset. An issue that is in flight when reset is asserted never emerges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Issue strobe for this cycle's operands |
| conj_i | input | 1 | Conjugate the second operand for this issue |
| rnd_i | input | 1 | Rounded 16-bit-part output for this issue |
| a_i | input | 64 | First operand, two packed complex elements |
| b_i | input | 64 | Second operand, two packed complex elements |
| vld_o | output | 1 | Result valid, three cycles after issue |
| res_o | output | 128 | Packed result, layout set by the issue's format flag |

## Verification
The sharpest collision is conjugation and saturation in the same issue. Negating a -32768 imaginary part yields +32768, and that can push a part to +2^31. That value must then clip in either output format. Table vectors force this with all-minimum operands in conjugate mode, and random streams bias parts toward 0x8000 and 0x7FFF. A second overlap is a rounded result and a widened result sitting in adjacent pipeline stages. The random stream changes both flags on every back-to-back issue, and each output is compared three cycles later against an independent arithmetic model of that issue's own flags.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // Number of register stages between issue and result.
    localparam int unsigned PIPE_DEPTH = 3;

    // Tag that travels beside the operands through the pipeline.
    typedef struct packed {
        logic vld;
        logic rnd;
    } cmul_tag_t;

endpackage

// File: rtl/cmul_fmt.sv
// Converts one exact product part into its widened (saturated) and its
// Q15 (rounded, saturated) representations.
module cmul_fmt #(
    parameter int unsigned PART_W = 16
) (
    input  logic signed [2*PART_W+1:0] sum_i,
    output logic        [2*PART_W-1:0] full_o,
    output logic        [PART_W-1:0]   narrow_o
);
    localparam int unsigned SUM_W = 2*PART_W + 2;
    localparam int unsigned WID_W = 2*PART_W;
    localparam int unsigned RND_W = SUM_W + 1;
    localparam logic [RND_W-1:0] HALF = RND_W'(1) << (PART_W-2);

    logic signed [SUM_W-1:0] wid_max;
    logic signed [SUM_W-1:0] wid_min;
    logic signed [RND_W-1:0] nar_max;
    logic signed [RND_W-1:0] nar_min;
    logic signed [RND_W-1:0] biased;
    logic signed [RND_W-1:0] shifted;

    assign wid_max = {{(SUM_W-WID_W+1){1'b0}}, {(WID_W-1){1'b1}}};
    assign wid_min = {{(SUM_W-WID_W+1){1'b1}}, {(WID_W-1){1'b0}}};
    assign nar_max = {{(RND_W-PART_W+1){1'b0}}, {(PART_W-1){1'b1}}};
    assign nar_min = {{(RND_W-PART_W+1){1'b1}}, {(PART_W-1){1'b0}}};

    assign biased  = $signed({sum_i[SUM_W-1], sum_i} + HALF);
    assign shifted = biased >>> (PART_W-1);

    always_comb begin
        if (sum_i > wid_max) begin
            full_o = wid_max[WID_W-1:0];
        end else if (sum_i < wid_min) begin
            full_o = wid_min[WID_W-1:0];
        end else begin
            full_o = sum_i[WID_W-1:0];
        end
    end

    always_comb begin
        if (shifted > nar_max) begin
            narrow_o = nar_max[PART_W-1:0];
        end else if (shifted < nar_min) begin
            narrow_o = nar_min[PART_W-1:0];
        end else begin
            narrow_o = shifted[PART_W-1:0];
        end
    end

endmodule

// File: rtl/cmul_lane.sv
// One complex lane: operand split and conjugation (stage 1), four partial
// products (stage 2), then combinational sums and formatting.
module cmul_lane #(
    parameter int unsigned PART_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*PART_W-1:0]   a_i,
    input  logic [2*PART_W-1:0]   b_i,
    input  logic                  conj_i,
    output logic [4*PART_W-1:0]   full_o,
    output logic [2*PART_W-1:0]   narrow_o
);
    localparam int unsigned PROD_W = 2*PART_W + 1;
    localparam int unsigned SUM_W  = 2*PART_W + 2;
    localparam int unsigned WID_W  = 2*PART_W;

    // stage 1 operands; second imaginary is one bit wider to hold +2^(W-1)
    logic signed [PART_W-1:0] ar_q, ai_q, br_q;
    logic signed [PART_W:0]   bi_q;
    logic signed [PART_W:0]   bi_ext;

    assign bi_ext = {b_i[PART_W-1], b_i[PART_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ar_q <= '0;
            ai_q <= '0;
            br_q <= '0;
            bi_q <= '0;
        end else begin
            ar_q <= a_i[2*PART_W-1:PART_W];
            ai_q <= a_i[PART_W-1:0];
            br_q <= b_i[2*PART_W-1:PART_W];
            bi_q <= conj_i ? -bi_ext : bi_ext;
        end
    end

    // sign-extended copies at product width
    logic signed [PROD_W-1:0] ar_x, ai_x, br_x, bi_x;
    assign ar_x = {{(PROD_W-PART_W){ar_q[PART_W-1]}}, ar_q};
    assign ai_x = {{(PROD_W-PART_W){ai_q[PART_W-1]}}, ai_q};
    assign br_x = {{(PROD_W-PART_W){br_q[PART_W-1]}}, br_q};
    assign bi_x = {{(PROD_W-PART_W-1){bi_q[PART_W]}}, bi_q};

    // stage 2 partial products
    logic signed [PROD_W-1:0] p_rr, p_ii, p_ri, p_ir;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_rr <= '0;
            p_ii <= '0;
            p_ri <= '0;
            p_ir <= '0;
        end else begin
            p_rr <= ar_x * br_x;
            p_ii <= ai_x * bi_x;
            p_ri <= ar_x * bi_x;
            p_ir <= ai_x * br_x;
        end
    end

    // exact parts: index 1 real, index 0 imaginary
    logic signed [SUM_W-1:0] part_sum [2];

    assign part_sum[1] = {p_rr[PROD_W-1], p_rr} - {p_ii[PROD_W-1], p_ii};
    assign part_sum[0] = {p_ri[PROD_W-1], p_ri} + {p_ir[PROD_W-1], p_ir};

    generate
        for (genvar k = 0; k < 2; k++) begin : g_part
            cmul_fmt #(.PART_W(PART_W)) i_fmt (
                .sum_i    (part_sum[k]),
                .full_o   (full_o[k*WID_W +: WID_W]),
                .narrow_o (narrow_o[k*PART_W +: PART_W])
            );
        end
    endgenerate

endmodule

// File: rtl/cmul_dual.sv
// Top: splits the packed operands into lanes, walks the valid/format tag
// beside the data and registers the selected result in stage 3.
module cmul_dual
    import cmul_pkg::*;
#(
    parameter int unsigned PART_W = 16,
    parameter int unsigned LANES  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             vld_i,
    input  logic                             conj_i,
    input  logic                             rnd_i,
    input  logic [LANES*2*PART_W-1:0]        a_i,
    input  logic [LANES*2*PART_W-1:0]        b_i,
    output logic                             vld_o,
    output logic [2*LANES*2*PART_W-1:0]      res_o
);
    localparam int unsigned EL_W  = 2*PART_W;
    localparam int unsigned OP_W  = LANES*EL_W;
    localparam int unsigned RES_W = 2*OP_W;

    logic [2*EL_W-1:0] lane_full [LANES];
    logic [EL_W-1:0]   lane_nar  [LANES];

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            cmul_lane #(.PART_W(PART_W)) i_lane (
                .clk      (clk),
                .rst_n    (rst_n),
                .a_i      (a_i[k*EL_W +: EL_W]),
                .b_i      (b_i[k*EL_W +: EL_W]),
                .conj_i   (conj_i),
                .full_o   (lane_full[k]),
                .narrow_o (lane_nar[k])
            );
        end
    endgenerate

    // tag pipeline for stages 1 and 2
    cmul_tag_t tag_q [PIPE_DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(PIPE_DEPTH) - 1; s++) begin
                tag_q[s] <= '0;
            end
        end else begin
            tag_q[0] <= '{vld: vld_i, rnd: rnd_i};
            for (int s = 1; s < int'(PIPE_DEPTH) - 1; s++) begin
                tag_q[s] <= tag_q[s-1];
            end
        end
    end

    // result assembly by format
    logic [RES_W-1:0] res_d;

    always_comb begin
        res_d = '0;
        for (int k = 0; k < int'(LANES); k++) begin
            if (tag_q[PIPE_DEPTH-2].rnd) begin
                res_d[k*EL_W +: EL_W] = lane_nar[k];
            end else begin
                res_d[k*2*EL_W +: 2*EL_W] = lane_full[k];
            end
        end
    end

    // stage 3 output register
    logic             vld_q;
    logic [RES_W-1:0] res_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= tag_q[PIPE_DEPTH-2].vld;
            res_q <= tag_q[PIPE_DEPTH-2].vld ? res_d : '0;
        end
    end

    assign vld_o = vld_q;
    assign res_o = res_q;

endmodule

// File: rtl/cmul_dual_chk.sv
module cmul_dual_chk #(
    parameter int unsigned PART_W = 16,
    parameter int unsigned LANES  = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          vld_i,
    input logic                          rnd_i,
    input logic [LANES*2*PART_W-1:0]     b_i,
    input logic                          vld_o,
    input logic [2*LANES*2*PART_W-1:0]   res_o
);
    localparam int unsigned RES_W = 2*LANES*2*PART_W;
    localparam int unsigned HALF_W = RES_W/2;

    // cycles since reset release, saturating, gates $past lookback
    logic [1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    a_r6_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (vld_o == $past(vld_i, 3)));

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && vld_o && $past(rnd_i, 3)) |-> (res_o[RES_W-1:HALF_W] == '0));

    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> (res_o == '0));

    a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && vld_o && $past(b_i, 3) == '0) |-> (res_o == '0));

endmodule

bind cmul_dual cmul_dual_chk #(.PART_W(PART_W), .LANES(LANES)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (vld_i),
    .rnd_i (rnd_i),
    .b_i   (b_i),
    .vld_o (vld_o),
    .res_o (res_o)
);

// File: tb/test_cmul_dual.sv
`timescale 1ns/1ps
module test_cmul_dual;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld_i = 1'b0;
    logic         conj_i = 1'b0;
    logic         rnd_i = 1'b0;
    logic [63:0]  a_i = '0;
    logic [63:0]  b_i = '0;
    logic         vld_o;
    logic [127:0] res_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmul_dual i_cmul_dual (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .conj_i(conj_i), .rnd_i(rnd_i),
        .a_i(a_i), .b_i(b_i), .vld_o(vld_o), .res_o(res_o)
    );

    // {a, b, conj, rnd, expected}
    localparam int NT = 8;
    localparam logic [257:0] TBL [NT] = '{
        {64'h0000_0000_0002_0003, 64'h0000_0000_0004_0005, 1'b0, 1'b0,
         128'h0000_0000_0000_0000_FFFF_FFF9_0000_0016},
        {64'h0000_0000_0002_0003, 64'h0000_0000_0004_0005, 1'b1, 1'b0,
         128'h0000_0000_0000_0000_0000_0017_0000_0002},
        {64'h8000_8000_0000_0000, 64'h8000_8000_0000_0000, 1'b0, 1'b0,
         128'h0000_0000_7FFF_FFFF_0000_0000_0000_0000},
        {64'h8000_8000_0000_0000, 64'h8000_8000_0000_0000, 1'b0, 1'b1,
         128'h0000_0000_0000_0000_0000_7FFF_0000_0000},
        {64'h8000_8000_0000_0000, 64'h8000_8000_0000_0000, 1'b1, 1'b0,
         128'h7FFF_FFFF_0000_0000_0000_0000_0000_0000},
        {64'hC000_0000_4000_0000, 64'h0001_0000_0001_0000, 1'b0, 1'b1,
         128'h0000_0000_0000_0000_0000_0000_0001_0000},
        {64'h0000_0000_8000_7FFF, 64'h0000_0000_7FFF_7FFF, 1'b0, 1'b1,
         128'h0000_0000_0000_0000_0000_0000_8000_FFFF},
        {64'h0000_0000_0000_4000, 64'h0000_0000_0000_4000, 1'b1, 1'b1,
         128'h0000_0000_0000_0000_0000_0000_2000_0000}
    };

    // independent arithmetic model of one issue
    function automatic logic [127:0] model(input logic [63:0] a, input logic [63:0] b,
                                           input logic cj, input logic rd);
        logic [127:0] r = '0;
        for (int l = 0; l < 2; l++) begin
            longint ar = $signed(a[l*32+16 +: 16]);
            longint ai = $signed(a[l*32 +: 16]);
            longint br = $signed(b[l*32+16 +: 16]);
            longint bi = $signed(b[l*32 +: 16]);
            longint re, im, qr, qi;
            if (cj) bi = -bi;
            re = ar*br - ai*bi;
            im = ar*bi + ai*br;
            if (rd) begin
                qr = (re + 16384) >>> 15;
                qi = (im + 16384) >>> 15;
                if (qr > 32767) qr = 32767;
                if (qr < -32768) qr = -32768;
                if (qi > 32767) qi = 32767;
                if (qi < -32768) qi = -32768;
                r[l*32 +: 32] = {qr[15:0], qi[15:0]};
            end else begin
                if (re > 64'sd2147483647) re = 64'sd2147483647;
                if (im > 64'sd2147483647) im = 64'sd2147483647;
                r[l*64 +: 64] = {re[31:0], im[31:0]};
            end
        end
        return r;
    endfunction

    task automatic check(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] pick_part();
        case ($urandom % 6)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'h0000;
            3: return 16'hFFFF;
            default: return 16'($urandom);
        endcase
    endfunction

    localparam int NS = 300;
    logic [127:0] exp_r [NS];
    logic         exp_v [NS];

    initial begin
        // R8: reset state while garbage is presented
        vld_i = 1'b1; a_i = 64'h1234_5678_9ABC_DEF0; b_i = 64'h0FED_CBA9_8765_4321;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R8 reset vld_o", {127'd0, vld_o}, 128'd0);
        check("R8 reset res_o", res_o, 128'd0);
        vld_i = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // table of hand-derived vectors (R2 R3 R4 R5), one issue at a time
        for (int i = 0; i < NT; i++) begin
            a_i = TBL[i][257:194]; b_i = TBL[i][193:130];
            conj_i = TBL[i][129]; rnd_i = TBL[i][128]; vld_i = 1'b1;
            @(negedge clk);
            vld_i = 1'b0;
            @(negedge clk);
            check($sformatf("R6 no early valid, vector %0d", i), {127'd0, vld_o}, 128'd0);
            @(negedge clk);
            check($sformatf("R6 valid after three edges, vector %0d", i), {127'd0, vld_o}, 128'd1);
            check($sformatf("R2 R3 R4 R5 table vector %0d", i), res_o, TBL[i][127:0]);
            check($sformatf("R2 model agrees, vector %0d", i), model(TBL[i][257:194],
                  TBL[i][193:130], TBL[i][129], TBL[i][128]), TBL[i][127:0]);
        end

        // R7: idle output with operands moving and no issue
        a_i = 64'hFFFF_FFFF_FFFF_FFFF; b_i = 64'h8000_8000_8000_8000; rnd_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 idle res_o zero", res_o, 128'd0);

        // R1 R3 R6: back-to-back random stream, flags change every issue
        for (int c = 0; c < NS + 3; c++) begin
            @(negedge clk);
            if (c >= 3) begin
                check($sformatf("R6 stream valid %0d", c-3), {127'd0, vld_o}, {127'd0, exp_v[c-3]});
                check($sformatf("R1 R3 R7 stream result %0d", c-3), res_o, exp_r[c-3]);
            end
            if (c < NS) begin
                vld_i  = ($urandom % 5) != 0;
                conj_i = $urandom % 2;
                rnd_i  = $urandom % 2;
                a_i = {pick_part(), pick_part(), pick_part(), pick_part()};
                b_i = {pick_part(), pick_part(), pick_part(), pick_part()};
                exp_v[c] = vld_i;
                exp_r[c] = vld_i ? model(a_i, b_i, conj_i, rnd_i) : 128'd0;
            end else begin
                vld_i = 1'b0;
            end
        end

        // R8: reset while an issue is in flight
        a_i = 64'h0002_0003_0002_0003; b_i = 64'h0004_0005_0004_0005;
        conj_i = 1'b0; rnd_i = 1'b0; vld_i = 1'b1;
        @(negedge clk);
        vld_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset mid-flight vld_o", {127'd0, vld_o}, 128'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 flushed issue never emerges", {127'd0, vld_o}, 128'd0);
        check("R8 flushed result zero", res_o, 128'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule